// File: doc/BRIEF.md
# Bitstream-Steered Sign-Flip Multiplier

This block forms the product of two (or, by parameter, three) held signed samples as a single one-bit stream, without any hardware multiplier. A chain of second-order delta-sigma modulators does the work. The first stage converts the first sample into a one-bit stream. Each later stage is fed either the next sample or its negation, and the bit that the stage before it produces in the same cycle picks which one. Over one update period of `PERIOD` clock cycles, the average of the last stage's ±1 output approaches the product of the samples, each normalised by the feedback gain `2^GL`.

Samples enter through a valid/ready handshake. A set of samples is taken when `smp_valid` and `smp_ready` are both high at a clock edge. `smp_ready` is high while the block is idle and in the final bit cycle of a running period. At any other time it is low, and the source must hold its data until it is accepted. When a set is taken, every modulator integrator is cleared and the period starts. A source that keeps `smp_valid` high therefore gets gapless back-to-back periods. The product stream (`prod_valid`, `prod_bit`) has no back-pressure: it is meant to drive a switching stage directly. For checking, the block also sums the ±1 output over each period and presents the total on `sum_value` with a one-cycle `sum_valid` pulse.

Top module: `sgnflip_mul`

## Requirements
- R1: After reset, `prod_valid`, `prod_bit` and `sum_valid` are 0, `sum_value` is 0 and `smp_ready` is 1.
- R2: A sample set is taken on a clock edge where `smp_valid` and `smp_ready` are both 1. `prod_valid` is then high for exactly `PERIOD` consecutive cycles, starting in the cycle after the taking edge.
- R3: `smp_ready` is 1 while idle and in the last bit cycle of a period, and 0 in every other running cycle. Data offered while `smp_ready` is 0 is not taken and does not change the running period's result.
- R4: `sum_valid` is a one-cycle pulse in the cycle after a period's last bit. `sum_value` (two's complement) equals the sum over that period's bits, where bit 1 counts +1 and bit 0 counts -1.
- R5: With `NIN`=2, sample x is `smp_data[W-1:0]` and sample y is `smp_data[2W-1:W]`, both two's complement. `sum_value` is within ±5 of `PERIOD*x*y/2^(2*GL)`.
- R6: Stage 0 is fed sample 0. Stage k≥1 is fed +sample k in a cycle where stage k-1 outputs 1, and -sample k where it outputs 0. Consequently, negating y negates the product to within the R5 tolerance on each side.
- R7: Every integrator is zero in the cycle after a sample set is taken, so equal samples give an identical `sum_value` whatever came before.
- R8: With `NIN`=3, the third sample is `smp_data[3W-1:2W]`. `sum_value` is within ±6 of `PERIOD*x*y*z/2^(3*GL)`.
- R9: For every sample value, including the most negative, the first integrator magnitude stays below `4*2^GL` and the second below `32*2^GL`. Full-scale products still meet R5.
- R10: `prod_bit` is 0 in every cycle where `prod_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample set offered |
| smp_ready | output | 1 | Block can take a sample set this cycle |
| smp_data | input | NIN*W | Packed samples, sample k in bits [k*W+W-1:k*W] |
| prod_valid | output | 1 | Product stream bit is live |
| prod_bit | output | 1 | Product stream bit, 1 = +1, 0 = -1 |
| sum_valid | output | 1 | One-cycle pulse marking a finished period sum |
| sum_value | output | $clog2(PERIOD)+2 | Signed sum of the ±1 bits of the last period |

## Verification
On every cycle, the bound checker watches several behaviours: the sign steering between stages, the integrator bounds, the clearing of integrators when a set is taken, the exact run length and the ready/last-cycle relation of each period, and the quiet output while idle. Only the bench's scenarios can show the arithmetic result. The bench sweeps every pair of 4-bit samples and compares each period sum with the arithmetic product. It also compares results for negated inputs, checks that back-to-back periods repeat exactly, and runs a set of three-input products against their expected values.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  // first integrator width for a feedback gain of 2^gl
  function automatic int int1_w(input int gl);
    return gl + 5;
  endfunction

  // second integrator width for a feedback gain of 2^gl
  function automatic int int2_w(input int gl);
    return gl + 8;
  endfunction

  // signed width that holds a sum of per ±1 terms
  function automatic int acc_w(input int per);
    return $clog2(per) + 2;
  endfunction

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

endpackage

// File: rtl/sfm_dsm2.sv
// Second-order one-bit modulator with two registered integrators.
module sfm_dsm2
  import sfm_pkg::*;
#(
  parameter int UW = 5,
  parameter int GL = 4,
  localparam int I1W = int1_w(GL),
  localparam int I2W = int2_w(GL)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  en,
  input  logic signed [UW-1:0]  u,
  output logic                  q,
  output logic signed [I1W-1:0] i1_o,
  output logic signed [I2W-1:0] i2_o
);

  localparam int FBV = 1 << GL;

  logic signed [I1W-1:0] i1_q, i1_d, fb1;
  logic signed [I2W-1:0] i2_q, i2_d, fb2;

  // quantizer: non-negative second integrator gives +1
  assign q = ~i2_q[I2W-1];

  always_comb begin
    fb1  = q ? I1W'(FBV) : -I1W'(FBV);
    fb2  = I2W'(fb1);
    i1_d = i1_q + I1W'(u) - fb1;
    i2_d = i2_q + I2W'(i1_d) - fb2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      i1_q <= '0;
      i2_q <= '0;
    end else if (en) begin
      i1_q <= i1_d;
      i2_q <= i2_d;
    end
  end

  assign i1_o = i1_q;
  assign i2_o = i2_q;

endmodule

// File: rtl/sfm_steer.sv
// Chooses +sample or -sample for a later stage from the earlier stage's bit.
module sfm_steer #(
  parameter int W = 4
) (
  input  logic                sel,
  input  logic signed [W-1:0] smp,
  output logic signed [W:0]   u
);

  logic signed [W:0] ext;

  always_comb begin
    ext = (W+1)'(smp);
    u   = sel ? ext : -ext;
  end

endmodule

// File: rtl/sfm_ctrl.sv
// Period sequencer and input handshake.
module sfm_ctrl
  import sfm_pkg::*;
#(
  parameter int PERIOD = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  output logic smp_ready,
  output logic take,
  output logic run,
  output logic last
);

  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  run_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign run       = (state_q == ST_RUN);
  assign last      = run && (cnt_q == CW'(PERIOD - 1));
  assign smp_ready = (state_q == ST_IDLE) || last;
  assign take      = smp_valid && smp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (take) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (last) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (run) begin
      cnt_q   <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/sfm_accum.sv
// Sums the ±1 product bits across one period.
module sfm_accum #(
  parameter int AW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 last,
  input  logic                 bit_i,
  output logic                 sum_valid,
  output logic signed [AW-1:0] sum_value
);

  logic signed [AW-1:0] acc_q, step;

  assign step = bit_i ? AW'(1) : -AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      sum_value <= '0;
      sum_valid <= 1'b0;
    end else begin
      sum_valid <= 1'b0;
      if (run) begin
        if (last) begin
          sum_value <= acc_q + step;
          sum_valid <= 1'b1;
          acc_q     <= '0;
        end else begin
          acc_q <= acc_q + step;
        end
      end
    end
  end

endmodule

// File: rtl/sgnflip_mul.sv
// Multiplier built from a chain of sign-steered delta-sigma modulators.
// GL must be at least W so every stage input stays within half the feedback.
module sgnflip_mul
  import sfm_pkg::*;
#(
  parameter int NIN    = 2,
  parameter int W      = 8,
  parameter int GL     = 8,
  parameter int PERIOD = 1024
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                smp_valid,
  output logic                                smp_ready,
  input  logic [NIN*W-1:0]                    smp_data,
  output logic                                prod_valid,
  output logic                                prod_bit,
  output logic                                sum_valid,
  output logic signed [acc_w(PERIOD)-1:0]     sum_value
);

  localparam int I1W = int1_w(GL);
  localparam int I2W = int2_w(GL);
  localparam int AW  = acc_w(PERIOD);
  localparam int UW  = W + 1;

  logic                 take, run, last;
  logic [NIN*W-1:0]     held_flat;
  logic [NIN-1:0]       stg_q;
  logic [NIN*UW-1:0]    stg_u_flat;
  logic [NIN*I1W-1:0]   stg_i1_flat;
  logic [NIN*I2W-1:0]   stg_i2_flat;

  sfm_ctrl #(.PERIOD(PERIOD)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .take      (take),
    .run       (run),
    .last      (last)
  );

  // sample registers, loaded once per accepted set
  always_ff @(posedge clk) begin
    if (!rst_n)    held_flat <= '0;
    else if (take) held_flat <= smp_data;
  end

  for (genvar k = 0; k < NIN; k++) begin : g_stage
    logic signed [UW-1:0]  u_k;
    logic signed [I1W-1:0] i1_k;
    logic signed [I2W-1:0] i2_k;

    if (k == 0) begin : g_head
      assign u_k = UW'($signed(held_flat[k*W +: W]));
    end else begin : g_link
      sfm_steer #(.W(W)) u_steer (
        .sel (stg_q[k-1]),
        .smp ($signed(held_flat[k*W +: W])),
        .u   (u_k)
      );
    end

    sfm_dsm2 #(.UW(UW), .GL(GL)) u_mod (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (take),
      .en    (run),
      .u     (u_k),
      .q     (stg_q[k]),
      .i1_o  (i1_k),
      .i2_o  (i2_k)
    );

    assign stg_u_flat[k*UW +: UW]    = u_k;
    assign stg_i1_flat[k*I1W +: I1W] = i1_k;
    assign stg_i2_flat[k*I2W +: I2W] = i2_k;
  end

  assign prod_valid = run;
  assign prod_bit   = run & stg_q[NIN-1];

  sfm_accum #(.AW(AW)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .last      (last),
    .bit_i     (stg_q[NIN-1]),
    .sum_valid (sum_valid),
    .sum_value (sum_value)
  );

endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
  parameter int NIN    = 2,
  parameter int W      = 4,
  parameter int GL     = 4,
  parameter int PERIOD = 256,
  parameter int I1W    = 9,
  parameter int I2W    = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic                 smp_ready,
  input logic                 prod_valid,
  input logic                 prod_bit,
  input logic                 sum_valid,
  input logic [NIN*W-1:0]     held_flat,
  input logic [NIN-1:0]       stg_q,
  input logic [NIN*(W+1)-1:0] stg_u_flat,
  input logic [NIN*I1W-1:0]   stg_i1_flat,
  input logic [NIN*I2W-1:0]   stg_i2_flat
);

  localparam int RW = $clog2(PERIOD) + 2;
  localparam logic signed [I1W-1:0] LIM1 = I1W'(4 << GL);
  localparam logic signed [I2W-1:0] LIM2 = I2W'(32 << GL);

  logic [RW-1:0] runcnt;

  // product-valid cycles seen since the last sum pulse
  always_ff @(posedge clk) begin
    if (!rst_n)         runcnt <= '0;
    else if (sum_valid) runcnt <= prod_valid ? RW'(1) : RW'(0);
    else if (prod_valid) runcnt <= runcnt + RW'(1);
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> prod_valid);

  assert_runlen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> (runcnt == RW'(PERIOD)));

  assert_ready_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_valid && smp_ready) |=> sum_valid);

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |=> !sum_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !prod_valid |-> !prod_bit);

  for (genvar k = 0; k < NIN; k++) begin : g_chk
    logic signed [W:0]     u_k, s_k;
    logic signed [I1W-1:0] i1_k;
    logic signed [I2W-1:0] i2_k;

    assign u_k  = $signed(stg_u_flat[k*(W+1) +: W+1]);
    assign s_k  = (W+1)'($signed(held_flat[k*W +: W]));
    assign i1_k = $signed(stg_i1_flat[k*I1W +: I1W]);
    assign i2_k = $signed(stg_i2_flat[k*I2W +: I2W]);

    if (k == 0) begin : g_head
      assert_head_feed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prod_valid |-> (u_k == s_k));
    end else begin : g_link
      assert_steer_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && stg_q[k-1]) |-> (u_k == s_k));
      assert_steer_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && !stg_q[k-1]) |-> (u_k == -s_k));
    end

    assert_int1_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (i1_k < LIM1) && (i1_k > -LIM1));

    assert_int2_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (i2_k < LIM2) && (i2_k > -LIM2));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_ready) |=> ((i1_k == '0) && (i2_k == '0)));
  end

endmodule

bind sgnflip_mul sfm_checker #(
  .NIN(NIN), .W(W), .GL(GL), .PERIOD(PERIOD), .I1W(I1W), .I2W(I2W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .prod_valid  (prod_valid),
  .prod_bit    (prod_bit),
  .sum_valid   (sum_valid),
  .held_flat   (held_flat),
  .stg_q       (stg_q),
  .stg_u_flat  (stg_u_flat),
  .stg_i1_flat (stg_i1_flat),
  .stg_i2_flat (stg_i2_flat)
);

// File: tb/sgnflip_mul_test.sv
module sgnflip_mul_test;

  localparam int W   = 4;
  localparam int GL  = 4;
  localparam int PER = 256;
  localparam int AW  = $clog2(PER) + 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst_n;

  logic                 v2, r2, pv2, pb2, sv2;
  logic [2*W-1:0]       d2;
  logic signed [AW-1:0] s2;

  logic                 v3, r3, pv3, pb3, sv3;
  logic [3*W-1:0]       d3;
  logic signed [AW-1:0] s3;

  sgnflip_mul #(.NIN(2), .W(W), .GL(GL), .PERIOD(PER)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(v2), .smp_ready(r2), .smp_data(d2),
    .prod_valid(pv2), .prod_bit(pb2), .sum_valid(sv2), .sum_value(s2)
  );

  sgnflip_mul #(.NIN(3), .W(W), .GL(GL), .PERIOD(PER)) uut3 (
    .clk(clk), .rst_n(rst_n), .smp_valid(v3), .smp_ready(r3), .smp_data(d3),
    .prod_valid(pv3), .prod_bit(pb3), .sum_valid(sv3), .sum_value(s3)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int res [16][16];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint labs(input longint a);
    return (a < 0) ? -a : a;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // one isolated two-input period: returns sum port, bit count and bench bit sum
  task automatic run2(input int x, input int y, output int sum, output int nb, output int bs);
    @(negedge clk);
    d2 = {W'(y), W'(x)};
    v2 = 1'b1;
    while (!r2) @(negedge clk);
    @(negedge clk);
    v2 = 1'b0;
    nb = 0;
    bs = 0;
    for (int t = 0; t < PER + 20 && !sv2; t++) begin
      if (pv2) begin
        nb++;
        bs += pb2 ? 1 : -1;
      end
      @(negedge clk);
    end
    sum = int'(s2);
  endtask

  task automatic run3(input int x, input int y, input int z, output int sum, output int nb);
    @(negedge clk);
    d3 = {W'(z), W'(y), W'(x)};
    v3 = 1'b1;
    while (!r3) @(negedge clk);
    @(negedge clk);
    v3 = 1'b0;
    nb = 0;
    for (int t = 0; t < PER + 20 && !sv3; t++) begin
      if (pv3) nb++;
      @(negedge clk);
    end
    sum = int'(s3);
  endtask

  initial begin
    int sum, nb, bs, sa, sb;
    int tx [6];
    int ty [6];
    int tz [6];
    rst_n = 1'b0;
    v2 = 1'b0; d2 = '0;
    v3 = 1'b0; d3 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pv2 == 1'b0, "R1 prod_valid", pv2, 0);
    check(pb2 == 1'b0, "R1 prod_bit", pb2, 0);
    check(sv2 == 1'b0, "R1 sum_valid", sv2, 0);
    check(s2 == '0, "R1 sum_value", s2, 0);
    check(r2 == 1'b1, "R1 smp_ready", r2, 1);

    // exhaustive two-input sweep: R2, R4, R5, R10
    for (int x = -8; x < 8; x++) begin
      for (int y = -8; y < 8; y++) begin
        longint num, got;
        run2(x, y, sum, nb, bs);
        res[x+8][y+8] = sum;
        num = longint'(PER) * x * y;
        got = longint'(sum) <<< (2*GL);
        check(nb == PER, "R2 period length", nb, PER);
        check(bs == sum, "R4 sum equals bit total", sum, bs);
        check(labs(got - num) <= (longint'(5) <<< (2*GL)), "R5 product",
              sum, num >>> (2*GL));
        check(pv2 == 1'b0 && pb2 == 1'b0, "R10 idle output", pb2, 0);
      end
    end

    // R6 sign symmetry through the steering
    for (int y = 1; y < 8; y++) begin
      foreach (tx[i]) begin
        if (i < 3) begin
          int xx;
          xx = (i == 0) ? -7 : ((i == 1) ? 3 : 6);
          check(labs(res[xx+8][y+8] + res[xx+8][8-y]) <= 10, "R6 negated y",
                res[xx+8][8-y], -res[xx+8][y+8]);
        end
      end
    end

    // R9 full-scale corners still accurate
    check(labs(res[0][0] - 64) <= 5, "R9 corner -8*-8", res[0][0], 64);
    check(labs(res[0][15] + 56) <= 5, "R9 corner -8*7", res[0][15], -56);
    check(labs(res[15][0] + 56) <= 5, "R9 corner 7*-8", res[15][0], -56);

    // R3 / R7 back-to-back periods with back-pressure
    @(negedge clk);
    d2 = {W'(-7), W'(5)};
    v2 = 1'b1;
    while (!r2) @(negedge clk);
    @(negedge clk);
    repeat (10) @(negedge clk);
    d2 = {W'(3), W'(-6)};
    check(r2 == 1'b0, "R3 ready low mid period", r2, 0);
    for (int t = 0; t < PER + 20 && !sv2; t++) @(negedge clk);
    sa = int'(s2);
    check(pv2 == 1'b1, "R3 gapless next period", pv2, 1);
    v2 = 1'b0;
    check(sa == res[5+8][-7+8], "R3 held data unchanged by offer", sa, res[5+8][-7+8]);
    @(negedge clk);
    for (int t = 0; t < PER + 20 && !sv2; t++) @(negedge clk);
    sb = int'(s2);
    check(sb == res[-6+8][3+8], "R7 repeat after history", sb, res[-6+8][3+8]);
    @(negedge clk);
    check(pb2 == 1'b0, "R10 idle after run", pb2, 0);

    // R8 three-input products
    tx = '{7, -8, 5, 0, -4, 3};
    ty = '{7, -8, -3, 7, 6, 3};
    tz = '{7, -8, 6, -8, 2, -7};
    foreach (tx[i]) begin
      longint num, got;
      run3(tx[i], ty[i], tz[i], sum, nb);
      num = longint'(PER) * tx[i] * ty[i] * tz[i];
      got = longint'(sum) <<< (3*GL);
      check(nb == PER, "R2 period length three-input", nb, PER);
      check(labs(got - num) <= (longint'(6) <<< (3*GL)), "R8 three-input product",
            sum, num >>> (3*GL));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule